// File: doc/BRIEF.md
# Wide Control Register with Atomic Commit

This block is a storage register that software controls over a narrow word bus while the value it holds is wider than one bus word. The value is cut into word slices, and each slice sits at its own consecutive bus address, starting at a base address. The logic around the register sees the whole value on one output. It gets a one-cycle strobe whenever a bus write changes the value. It can also load a complete new value itself through a load port.

In atomic mode, the bus writes the upper slices into a hidden shadow buffer. The visible value stays unchanged until the slice at the highest address is written. That write moves the shadow buffer and the incoming word into the value in one cycle, so downstream logic never sees a half-updated setting. In direct mode, every word write takes effect in its own slice on its own.

The reset value is assembled from a list of bit fields, each with an offset, width and reset value. Any 1-bit field can be marked as self-clearing. It then stays set only for the one cycle after a write of 1. Reads are combinational and return the live value, so a multi-word read can mix old and new slices if the value changes between the word reads.

Top module: `wide_ctrl_reg`

## Requirements
- R1: The value is split into NWORDS = ceil(REG_W/DATA_W) words at addresses BASE to BASE+NWORDS-1. The word at BASE holds the most significant bits, and the word at BASE+NWORDS-1 holds value[DATA_W-1:0]. Word k holds value bits [(NWORDS-1-k)*DATA_W +: DATA_W]. The read data returns that word combinationally in the same cycle.
- R2: Bits of the top word above REG_W read as zero and are dropped on write. Addresses outside the window read as zero, and writes to them change neither the value nor the strobe.
- R3: In atomic mode, a write to any word except the last one stores into the shadow buffer only and leaves the visible value unchanged. Self-clearing bits still clear.
- R4: In atomic mode, a write to the last word loads {shadow, write data}, truncated to REG_W bits. The new value is visible from the clock edge that takes the write.
- R5: In direct mode, each in-range word write replaces only its own slice, visible from the clock edge that takes the write.
- R6: wr_stb is high for exactly the one cycle after each edge at which a bus write updates the value. In atomic mode that is only the last-word write; in direct mode it is every in-range write. wr_stb stays low otherwise.
- R7: A load (dev_we high) puts dev_wdata into the value at the next edge and does not raise wr_stb.
- R8: When a bus update and a load fall on the same edge, the bus update is applied and the load is dropped.
- R9: After reset, the value is the OR of each field's reset value shifted to its offset, with self-clearing fields at zero. With the default fields this is 20'h9C456. The shadow buffer resets to the upper part of that value.
- R10: A self-clearing field (the default is bit 0) reads 1 for one cycle after it is written or loaded with 1, and reads 0 after that unless it is written again.
- R11: Word reads are not atomic. A load that happens between two word reads shows its new bits in the later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | DATA_W | Bus write word |
| bus_rdata | output | DATA_W | Word at bus_addr, zero outside the window |
| value | output | REG_W | Full register value |
| wr_stb | output | 1 | One-cycle pulse after a bus update of the value |
| dev_we | input | 1 | Load enable from the surrounding logic |
| dev_wdata | input | REG_W | Full-width value to load |

## Verification
A shadow buffer that holds stale or misplaced bytes stays invisible until the next commit. It then shows up as wrong upper bits on `value` in the cycle right after the last-word write. A slice-indexing fault in the read or write path shows up in the same cycle as a swapped or zeroed word on `bus_rdata`, or as a changed neighbouring slice on `value`. A stuck strobe or self-clearing bit is exposed one idle cycle later, when it fails to drop back to zero.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

  // Kind of bus access seen in the current cycle.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_SHADOW = 2'd1,
    ACC_COMMIT = 2'd2
  } acc_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // One field's reset contribution, masked to its width and moved to its offset.
  function automatic logic [63:0] field_bits(input int ofs, input int wid, input logic [63:0] rst);
    logic [63:0] m;
    m = (wid >= 64) ? '1 : ((64'd1 << wid) - 64'd1);
    return (rst & m) << ofs;
  endfunction

endpackage

// File: rtl/wreg_decode.sv
module wreg_decode
  import wreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 16,
  parameter int NWORDS = 3,
  parameter bit ATOMIC = 1'b1,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output acc_e              kind
);

  localparam logic [ADDR_W:0] BASE_X   = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] NWORDS_X = (ADDR_W+1)'(NWORDS);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NWORDS - 1);

  logic [ADDR_W:0] off;
  logic            is_last;

  always_comb begin
    off     = {1'b0, addr} - BASE_X;
    hit     = ({1'b0, addr} >= BASE_X) && (off < NWORDS_X);
    idx     = off[IDX_W-1:0];
    is_last = (idx == LAST);
    if (!(we && hit)) begin
      kind = ACC_NONE;
    end else if (ATOMIC && !is_last) begin
      kind = ACC_SHADOW;
    end else begin
      kind = ACC_COMMIT;
    end
  end

endmodule

// File: rtl/wreg_shadow.sv
module wreg_shadow #(
  parameter int DATA_W             = 8,
  parameter int NWORDS             = 3,
  parameter int IDX_W              = 2,
  parameter int SH_W               = 16,
  parameter logic [SH_W-1:0] SH_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [SH_W-1:0]   shadow
);

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;
  logic [NWORDS-2:0] sel;

  // One select per shadow word; word k of the window maps to shadow slice NWORDS-2-k.
  for (genvar k = 0; k < NWORDS - 1; k++) begin : g_sel
    assign sel[k] = wr_en && (idx == IDX_W'(k));
  end

  always_comb begin
    sh_d = sh_q;
    for (int k = 0; k < NWORDS - 1; k++) begin
      if (sel[k]) begin
        sh_d[(NWORDS-2-k)*DATA_W +: DATA_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= SH_RST;
    end else if (wr_en) begin
      sh_q <= sh_d;
    end
  end

  assign shadow = sh_q;

endmodule

// File: rtl/wreg_core.sv
module wreg_core
  import wreg_pkg::*;
#(
  parameter int REG_W                     = 20,
  parameter int DATA_W                    = 8,
  parameter int NWORDS                    = 3,
  parameter int IDX_W                     = 2,
  parameter int SH_W                      = 16,
  parameter bit ATOMIC                    = 1'b1,
  parameter bit DEV_LOAD                  = 1'b1,
  parameter logic [REG_W-1:0] RST_VAL     = '0,
  parameter logic [REG_W-1:0] PULSE_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SH_W-1:0]   shadow,
  input  logic              dev_we,
  input  logic [REG_W-1:0]  dev_wdata,
  output logic [REG_W-1:0]  value,
  output logic              stb
);

  localparam int PAD_W = NWORDS * DATA_W;

  logic [REG_W-1:0] val_q;
  logic [REG_W-1:0] val_d;
  logic [PAD_W-1:0] pad;
  logic             val_en;
  logic             stb_q;
  logic             stb_d;
  logic             load_ok;

  assign load_ok = DEV_LOAD && dev_we;

  // Next-state: self-clearing bits drop first, then a bus update or a load.
  always_comb begin
    val_d = val_q & ~PULSE_MASK;
    pad   = PAD_W'(val_d);
    stb_d = 1'b0;
    if (kind == ACC_COMMIT) begin
      stb_d = 1'b1;
      if (ATOMIC) begin
        val_d = REG_W'({shadow, wdata});
      end else begin
        pad[(NWORDS-1-int'(idx))*DATA_W +: DATA_W] = wdata;
        val_d = pad[REG_W-1:0];
      end
    end else if (load_ok) begin
      val_d = dev_wdata;
    end
  end

  // Clock enable: any commit, any load, or a set self-clearing bit to drop.
  assign val_en = (kind == ACC_COMMIT) || load_ok || (|(val_q & PULSE_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= RST_VAL;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign value = val_q;
  assign stb   = stb_q;

endmodule

// File: rtl/wreg_rdmux.sv
module wreg_rdmux #(
  parameter int REG_W  = 20,
  parameter int DATA_W = 8,
  parameter int NWORDS = 3,
  parameter int IDX_W  = 2
) (
  input  logic [REG_W-1:0]  value,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = NWORDS * DATA_W;

  logic [PAD_W-1:0]  pad;
  logic [DATA_W-1:0] words [NWORDS];

  assign pad = PAD_W'(value);

  // Word k of the window carries the slice counted from the top.
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign words[k] = pad[(NWORDS-1-k)*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (hit && (idx == IDX_W'(k))) begin
        rdata = words[k];
      end
    end
  end

endmodule

// File: rtl/wide_ctrl_reg.sv
module wide_ctrl_reg
  import wreg_pkg::*;
#(
  parameter int DATA_W                  = 8,
  parameter int REG_W                   = 20,
  parameter int ADDR_W                  = 8,
  parameter int BASE                    = 16,
  parameter bit ATOMIC                  = 1'b1,
  parameter bit DEV_LOAD                = 1'b1,
  parameter int FLD_N                   = 4,
  parameter logic [FLD_N*8-1:0]  FLD_OFS   = {8'd16, 8'd8, 8'd1, 8'd0},
  parameter logic [FLD_N*8-1:0]  FLD_WID   = {8'd4, 8'd8, 8'd7, 8'd1},
  parameter logic [FLD_N*32-1:0] FLD_RST   = {32'h9, 32'hC4, 32'h2B, 32'h0},
  parameter logic [FLD_N-1:0]    FLD_PULSE = 4'b0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [REG_W-1:0]  value,
  output logic              wr_stb,
  input  logic              dev_we,
  input  logic [REG_W-1:0]  dev_wdata
);

  localparam int NWORDS = ceil_div(REG_W, DATA_W);
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PAD_W  = NWORDS * DATA_W;
  localparam int SH_W   = (NWORDS > 1) ? (NWORDS - 1) * DATA_W : 1;

  // Self-clearing fields occupy one bit at their offset.
  function automatic logic [REG_W-1:0] calc_pulse();
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < FLD_N; i++) begin
      if (FLD_PULSE[i]) begin
        acc |= 64'd1 << int'(FLD_OFS[i*8 +: 8]);
      end
    end
    return acc[REG_W-1:0];
  endfunction

  // OR of all field reset values at their offsets.
  function automatic logic [REG_W-1:0] calc_rst();
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < FLD_N; i++) begin
      acc |= field_bits(int'(FLD_OFS[i*8 +: 8]), int'(FLD_WID[i*8 +: 8]),
                        64'(FLD_RST[i*32 +: 32]));
    end
    return acc[REG_W-1:0];
  endfunction

  localparam logic [REG_W-1:0] PULSE_MASK = calc_pulse();
  localparam logic [REG_W-1:0] RST_VAL    = calc_rst() & ~PULSE_MASK;
  localparam logic [PAD_W-1:0] RST_PAD    = PAD_W'(RST_VAL);
  localparam logic [SH_W-1:0]  SH_RST     = SH_W'(RST_PAD >> DATA_W);

  logic             hit;
  logic [IDX_W-1:0] idx;
  acc_e             kind;
  logic [SH_W-1:0]  shadow;

  wreg_decode #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .NWORDS (NWORDS),
    .ATOMIC (ATOMIC),
    .IDX_W  (IDX_W)
  ) u_decode (
    .addr (bus_addr),
    .we   (bus_we),
    .hit  (hit),
    .idx  (idx),
    .kind (kind)
  );

  if (ATOMIC && (NWORDS > 1)) begin : g_shadow
    wreg_shadow #(
      .DATA_W (DATA_W),
      .NWORDS (NWORDS),
      .IDX_W  (IDX_W),
      .SH_W   (SH_W),
      .SH_RST (SH_RST)
    ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (kind == ACC_SHADOW),
      .idx    (idx),
      .wdata  (bus_wdata),
      .shadow (shadow)
    );
  end else begin : g_no_shadow
    assign shadow = '0;
  end

  wreg_core #(
    .REG_W      (REG_W),
    .DATA_W     (DATA_W),
    .NWORDS     (NWORDS),
    .IDX_W      (IDX_W),
    .SH_W       (SH_W),
    .ATOMIC     (ATOMIC),
    .DEV_LOAD   (DEV_LOAD),
    .RST_VAL    (RST_VAL),
    .PULSE_MASK (PULSE_MASK)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .idx       (idx),
    .wdata     (bus_wdata),
    .shadow    (shadow),
    .dev_we    (dev_we),
    .dev_wdata (dev_wdata),
    .value     (value),
    .stb       (wr_stb)
  );

  wreg_rdmux #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W),
    .NWORDS (NWORDS),
    .IDX_W  (IDX_W)
  ) u_rdmux (
    .value (value),
    .hit   (hit),
    .idx   (idx),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/wide_ctrl_reg_chk.sv
module wide_ctrl_reg_chk #(
  parameter int DATA_W                 = 8,
  parameter int REG_W                  = 20,
  parameter int ADDR_W                 = 8,
  parameter int BASE                   = 16,
  parameter bit ATOMIC                 = 1'b1,
  parameter bit DEV_LOAD               = 1'b1,
  parameter int NWORDS                 = 3,
  parameter logic [REG_W-1:0] PULSE_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [REG_W-1:0]  value,
  input logic              wr_stb,
  input logic              dev_we,
  input logic [REG_W-1:0]  dev_wdata
);

  localparam int TOP_USED = REG_W - (NWORDS - 1) * DATA_W;

  logic in_rng;
  logic is_last;
  logic cpu_upd;

  assign in_rng  = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + NWORDS);
  assign is_last = (int'(bus_addr) == BASE + NWORDS - 1);
  assign cpu_upd = bus_we && in_rng && (!ATOMIC || is_last);

  // R2: outside the window the read data is zero
  a_r2_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |-> (bus_rdata == '0));

  // R2: bits above REG_W in the top word read as zero
  a_r2_top_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == BASE) |-> ((bus_rdata >> TOP_USED) == '0));

  // R3: a shadow write leaves the non-self-clearing bits untouched
  a_r3_shadow_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (ATOMIC && bus_we && in_rng && !is_last && !dev_we) |=> $stable(value & ~PULSE_MASK));

  // R4: the commit places the last written word in the low slice
  a_r4_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_last) |=> (value[DATA_W-1:0] == $past(bus_wdata)));

  // R6: a bus update is followed by the strobe
  a_r6_stb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_upd |=> wr_stb);

  // R6: the strobe has a bus update as its cause
  a_r6_stb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(cpu_upd));

  // R7: a lone load lands in full
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (DEV_LOAD && dev_we && !cpu_upd) |=> (value == $past(dev_wdata)));

  // R10: a set self-clearing bit drops after one cycle when nothing sets it again
  a_r10_pulse_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (((value & PULSE_MASK) != '0) && !cpu_upd && !dev_we) |=> ((value & PULSE_MASK) == '0));

endmodule

bind wide_ctrl_reg wide_ctrl_reg_chk #(
  .DATA_W     (DATA_W),
  .REG_W      (REG_W),
  .ADDR_W     (ADDR_W),
  .BASE       (BASE),
  .ATOMIC     (ATOMIC),
  .DEV_LOAD   (DEV_LOAD),
  .NWORDS     (NWORDS),
  .PULSE_MASK (PULSE_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .value     (value),
  .wr_stb    (wr_stb),
  .dev_we    (dev_we),
  .dev_wdata (dev_wdata)
);

// File: tb/wide_ctrl_reg_tb.sv
`timescale 1ns/1ps
module wide_ctrl_reg_tb;

  localparam int          BASE = 16;
  localparam logic [19:0] RSTV = 20'h9C456;
  localparam logic [19:0] PM   = 20'h00001;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  rd_a, rd_n;
  logic [19:0] val_a, val_n;
  logic        stb_a, stb_n;
  logic        dev_we;
  logic [19:0] dev_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench models
  logic [19:0] ea, en;
  logic [15:0] sa;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  wide_ctrl_reg #(.ATOMIC(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .value(val_a), .wr_stb(stb_a),
    .dev_we(dev_we), .dev_wdata(dev_wdata));

  wide_ctrl_reg #(.ATOMIC(1'b0)) u_dut_na (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rd_n), .value(val_n), .wr_stb(stb_n),
    .dev_we(dev_we), .dev_wdata(dev_wdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] word_of(input logic [19:0] v, input int k);
    logic [23:0] p;
    p = {4'b0, v};
    if (k < 0 || k > 2) return 8'h00;
    return p[(2-k)*8 +: 8];
  endfunction

  // One clock passes with no update: self-clearing bits drop in the models.
  task automatic step();
    @(negedge clk);
    ea = ea & ~PM;
    en = en & ~PM;
  endtask

  task automatic wr(input string req, input logic [7:0] a, input logic [7:0] d,
                    input bit dv = 1'b0, input logic [19:0] dd = 20'h0);
    int k;
    bit inr;
    logic [23:0] p;
    step();
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    dev_we = dv; dev_wdata = dd;
    k   = int'(a) - BASE;
    inr = (k >= 0) && (k < 3);
    // atomic model
    ea = ea & ~PM;
    if (inr && k < 2) sa[(1-k)*8 +: 8] = d;
    if (inr && k == 2) ea = {sa[11:0], d};
    else if (dv) ea = dd;
    // direct model
    en = en & ~PM;
    if (inr) begin
      p = {4'b0, en};
      p[(2-k)*8 +: 8] = d;
      en = p[19:0];
    end else if (dv) begin
      en = dd;
    end
    @(negedge clk);
    bus_we = 1'b0; dev_we = 1'b0;
    #1;
    chk({req, " value atomic"}, 32'(val_a), 32'(ea));
    chk({req, " value direct"}, 32'(val_n), 32'(en));
    chk("R6 stb atomic", 32'(stb_a), 32'(inr && k == 2));
    chk("R6 stb direct", 32'(stb_n), 32'(inr));
  endtask

  task automatic dload(input logic [19:0] dd);
    step();
    dev_we = 1'b1; dev_wdata = dd;
    @(negedge clk);
    dev_we = 1'b0;
    ea = dd; en = dd;
    #1;
    chk("R7 load atomic", 32'(val_a), 32'(dd));
    chk("R7 load direct", 32'(val_n), 32'(dd));
    chk("R7 no stb", 32'({stb_a, stb_n}), 32'd0);
  endtask

  task automatic idle(input string req);
    step();
    #1;
    chk({req, " idle atomic"}, 32'(val_a), 32'(ea));
    chk({req, " idle direct"}, 32'(val_n), 32'(en));
    chk("R6 stb low", 32'({stb_a, stb_n}), 32'd0);
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    step();
    bus_addr = a;
    #1;
    chk({req, " read atomic"}, 32'(rd_a), 32'(word_of(ea, int'(a) - BASE)));
    chk({req, " read direct"}, 32'(rd_n), 32'(word_of(en, int'(a) - BASE)));
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ea = RSTV; en = RSTV; sa = 16'h09C4;
    #1;
    chk("R9 reset atomic", 32'(val_a), 32'(RSTV));
    chk("R9 reset direct", 32'(val_n), 32'(RSTV));
    chk("R9 reset stb", 32'({stb_a, stb_n}), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    dev_we = 1'b0; dev_wdata = '0;
    ea = RSTV; en = RSTV; sa = 16'h09C4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset value", 32'(val_a), 32'(RSTV));
    chk("R9 reset stb", 32'(stb_a), 32'd0);
    for (int k = 0; k < 3; k++) rd("R1 reset words", 8'(BASE + k));

    // Sweep: each value written word by word, top word with junk in the unused nibble
    for (int i = 0; i < 64; i++) begin
      logic [19:0] v;
      v = 20'(i * 32'h2F3A5 + 32'h13);
      wr("R3 R5 top word", 8'(BASE),     {4'(i) ^ 4'hA, v[19:16]});
      wr("R3 R5 mid word", 8'(BASE + 1), v[15:8]);
      wr("R4 R5 last word", 8'(BASE + 2), v[7:0]);
      chk("R4 commit value", 32'(val_a), 32'(v));
      idle("R10");
      for (int k = 0; k < 3; k++) rd("R1 R2 word", 8'(BASE + k));
    end

    // Out-of-window writes and reads
    wr("R2 below window", 8'(BASE - 1), 8'h5A);
    wr("R2 above window", 8'(BASE + 3), 8'hA5);
    rd("R2 oob read low", 8'(BASE - 1));
    rd("R2 oob read high", 8'(BASE + 3));

    // Self-clearing bit via write and via load
    wr("R10 set pulse", 8'(BASE + 2), 8'h01);
    chk("R10 pulse high", 32'(val_a[0]), 32'd1);
    idle("R10 pulse drop");
    chk("R10 pulse low", 32'(val_a[0]), 32'd0);
    dload(20'h3C3C1);
    idle("R10 load pulse drop");

    // Loads with several patterns
    dload(20'hFFFFF);
    dload(20'h00000);
    dload(20'hA5A5A);

    // Collision: bus update against load on the same edge
    wr("R8 collide last", 8'(BASE + 2), 8'h77, 1'b1, 20'h12345);
    wr("R8 collide mid", 8'(BASE + 1), 8'h66, 1'b1, 20'h54321);

    // Torn read across a load
    dload(20'h11111);
    rd("R11 first word", 8'(BASE));
    dload(20'hEDCBA);
    rd("R11 later word", 8'(BASE + 2));
    chk("R11 torn low", 32'(rd_a), 32'h000000BA);

    // Mid-run reset restores value and shadow
    wr("R3 preload shadow", 8'(BASE), 8'h0F);
    do_reset();
    wr("R9 shadow reset commit", 8'(BASE + 2), 8'h3E);
    chk("R9 shadow reset", 32'(val_a), 32'h9C43E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule